// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar as seven packed-BCD bytes: seconds, minutes, hours, day-of-week, date, month and a two-digit year. A base tick arrives `TICKS_PER_SEC` times per second. An internal prescaler turns those ticks into one-second steps, and each step ripples a carry up the chain of fields. Month lengths and leap years are handled in hardware. Hours are presented in 24-hour form or in 12-hour form with an afternoon flag, selected by a plain mode pin.

Software loads any field through a plain write strobe with a 3-bit field select and a data byte. There is no back-pressure: a write is taken in the cycle it is presented. While the freeze pin is high, the outputs show a held copy of the time so that a reader walking across several bytes sees one coherent instant. Counting carries on underneath, and the outputs catch up as soon as freeze drops. Each field has a one-cycle rollover strobe.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59, wrap to 00, and carry into the next field. Seconds advance once per `TICKS_PER_SEC` base ticks.
- R2: The hour is held as 00 to 23. A wrap from 23 to 00 advances the day.
- R3: With `mode_12h_i` high, `hour_o` has bit 7 set, bit 6 clear, bit 5 set for afternoon, and bits 4:0 holding BCD 01 to 12. The sequence runs 12, 01 to 11, and the afternoon flag flips on each 11-to-12 step. With the pin low, `hour_o` is BCD 00 to 23 with bits 7:6 clear.
- R4: The date wraps to 01 after 30 in April, June, September and November, after 31 in the other long months, and after 28 or 29 in February.
- R5: A year divisible by four, 00 included, gives February 29 days.
- R6: Day-of-week counts 1 to 7, wraps to 1, and steps on the same edge as the date.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R8: A write with field select 0 to 6 loads seconds, minutes, hour, day-of-week, date, month or year. Select 7 changes nothing. A written field takes the data even if an increment would reach it in the same cycle, and that carry is dropped. A 12-hour write has bit 7 set, bit 5 as the afternoon flag and BCD 01 to 12 in bits 4:0. A 24-hour write has bit 7 clear.
- R9: Any seconds write clears the prescaler, so the next seconds step follows exactly `TICKS_PER_SEC` further ticks.
- R10: While `freeze_i` is high, the outputs hold the time last shown. Ticks and writes still act on the live count, and the outputs show the live time once freeze is low.
- R11: `roll_o[i]` pulses for one cycle, aligned with the new value, when field i wraps. The bit order is seconds (0), minutes, hour, day-of-week, date, month, year (6).
- R12: After reset the time is 00:00:00, day-of-week 1, date 01, month 01 and year 00, and `roll_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base tick, `TICKS_PER_SEC` per second |
| mode_12h_i | input | 1 | Hour presentation: 1 = 12-hour |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field select |
| wr_data_i | input | 8 | BCD data to load |
| freeze_i | input | 1 | Hold outputs for a coherent read |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour, format per R3 |
| dow_o | output | 8 | Day-of-week, 1..7 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| roll_o | output | 7 | Per-field wrap strobes |

## Verification
A field write and a one-second advance can land in the same cycle. The bench provokes this by feeding `TICKS_PER_SEC`-1 ticks to bring the prescaler to its last count, then presenting a minutes write, or a seconds write, together with the final tick. A pass requires that the written field holds exactly the data and that the seconds wrap and its strobe still happen. The carry into the written field must vanish, and a seconds write must cancel the step it collided with. Random runs repeat this collision many times, with freeze and mode changes layered on top.

// File: rtl/rtcc_pkg.sv
`timescale 1ns/1ps
package rtcc_pkg;
  localparam int FIELD_CNT = 7;
  localparam int IX_SEC   = 0;
  localparam int IX_MIN   = 1;
  localparam int IX_HOUR  = 2;
  localparam int IX_DOW   = 3;
  localparam int IX_DATE  = 4;
  localparam int IX_MONTH = 5;
  localparam int IX_YEAR  = 6;

  typedef logic [7:0] bcd8_t;

  // lowest legal value of each field, also its reset value (index 6 leftmost)
  localparam logic [FIELD_CNT-1:0][7:0] FLD_BASE =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(bcd8_t v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic bcd8_t bin_to_bcd(logic [6:0] b);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = b / 7'd10;
    ones = b % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  // year in BCD divisible by four: odd tens digit needs ones 2/6, even needs 0/4/8
  function automatic logic is_leap(bcd8_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd8_t month_last(bcd8_t m, logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // internal 24-hour BCD value to the presented form
  function automatic bcd8_t hour_to_ext(bcd8_t h24, logic m12);
    logic [6:0] b;
    logic [6:0] h12;
    logic       pm;
    bcd8_t      e;
    b   = bcd_to_bin(h24);
    pm  = (b >= 7'd12);
    h12 = (b == 7'd0) ? 7'd12 : ((b > 7'd12) ? b - 7'd12 : b);
    e   = bin_to_bcd(h12);
    if (!m12) return {2'b00, h24[5:0]};
    return {1'b1, 1'b0, pm, e[4:0]};
  endfunction

  // written byte (either form) to the internal 24-hour BCD value
  function automatic bcd8_t hour_from_ext(bcd8_t d);
    logic [6:0] h;
    logic [6:0] b;
    h = bcd_to_bin({3'b000, d[4:0]});
    b = ((h == 7'd12) ? 7'd0 : h) + (d[5] ? 7'd12 : 7'd0);
    if (d[7]) return bin_to_bcd(b);
    return {2'b00, d[5:0]};
  endfunction
endpackage

// File: rtl/rtcc_prescaler.sv
`timescale 1ns/1ps
module rtcc_prescaler #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clear_i,
  output logic step_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = tick_i && !clear_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) cnt_q <= '0;
    else if (tick_i)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtcc_bcd_field.sv
`timescale 1ns/1ps
module rtcc_bcd_field
  import rtcc_pkg::*;
#(
  parameter bcd8_t LOW = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  logic  load_i,
  input  bcd8_t load_val_i,
  input  bcd8_t top_i,
  output bcd8_t val_o,
  output bcd8_t nxt_o,
  output logic  wrap_o
);
  bcd8_t val_q;

  assign val_o  = val_q;
  assign wrap_o = step_i && !load_i && (val_q == top_i);

  always_comb begin
    if (load_i)      nxt_o = load_val_i;
    else if (step_i) nxt_o = (val_q == top_i) ? LOW : bcd_inc(val_q);
    else             nxt_o = val_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) val_q <= LOW;
    else        val_q <= nxt_o;
  end
endmodule

// File: rtl/rtcc_freeze_view.sv
`timescale 1ns/1ps
module rtcc_freeze_view #(
  parameter int N = 7,
  parameter logic [N-1:0][7:0] RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic [N-1:0][7:0] live_i,
  input  logic [N-1:0][7:0] live_nxt_i,
  output logic [N-1:0][7:0] view_o
);
  logic [N-1:0][7:0] snap_q;

  for (genvar g = 0; g < N; g++) begin : g_snap
    // capture the value the live field takes at this edge
    always_ff @(posedge clk) begin
      if (!rst_n)         snap_q[g] <= RST[g];
      else if (!freeze_i) snap_q[g] <= live_nxt_i[g];
    end
    assign view_o[g] = freeze_i ? snap_q[g] : live_i[g];
  end
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
  import rtcc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       mode_12h_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       freeze_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [6:0] roll_o
);
  logic [FIELD_CNT-1:0]      load;
  logic [FIELD_CNT-1:0]      step;
  logic [FIELD_CNT-1:0]      wrap;
  logic [FIELD_CNT-1:0][7:0] top;
  logic [FIELD_CNT-1:0][7:0] load_val;
  logic [FIELD_CNT-1:0][7:0] live_q;
  logic [FIELD_CNT-1:0][7:0] live_d;
  logic [FIELD_CNT-1:0][7:0] view;
  logic [FIELD_CNT-1:0]      roll_q;
  logic                      sec_step;

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_load
    assign load[g] = wr_en_i && (wr_addr_i == 3'(g));
  end

  rtcc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .clear_i (load[IX_SEC]),
    .step_o  (sec_step)
  );

  // carry chain: day-of-week and date both step on the hour wrap
  assign step[IX_SEC]   = sec_step;
  assign step[IX_MIN]   = wrap[IX_SEC];
  assign step[IX_HOUR]  = wrap[IX_MIN];
  assign step[IX_DOW]   = wrap[IX_HOUR];
  assign step[IX_DATE]  = wrap[IX_HOUR];
  assign step[IX_MONTH] = wrap[IX_DATE];
  assign step[IX_YEAR]  = wrap[IX_MONTH];

  assign top[IX_SEC]   = 8'h59;
  assign top[IX_MIN]   = 8'h59;
  assign top[IX_HOUR]  = 8'h23;
  assign top[IX_DOW]   = 8'h07;
  assign top[IX_DATE]  = month_last(live_q[IX_MONTH], is_leap(live_q[IX_YEAR]));
  assign top[IX_MONTH] = 8'h12;
  assign top[IX_YEAR]  = 8'h99;

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_fld
    if (g == IX_HOUR) begin : g_hr
      assign load_val[g] = hour_from_ext(wr_data_i);
    end else begin : g_plain
      assign load_val[g] = wr_data_i;
    end
    rtcc_bcd_field #(.LOW(FLD_BASE[g])) u_fld (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step[g]),
      .load_i     (load[g]),
      .load_val_i (load_val[g]),
      .top_i      (top[g]),
      .val_o      (live_q[g]),
      .nxt_o      (live_d[g]),
      .wrap_o     (wrap[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) roll_q <= '0;
    else        roll_q <= wrap;
  end

  rtcc_freeze_view #(.N(FIELD_CNT), .RST(FLD_BASE)) u_view (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_i   (freeze_i),
    .live_i     (live_q),
    .live_nxt_i (live_d),
    .view_o     (view)
  );

  assign sec_o   = view[IX_SEC];
  assign min_o   = view[IX_MIN];
  assign hour_o  = hour_to_ext(view[IX_HOUR], mode_12h_i);
  assign dow_o   = view[IX_DOW];
  assign date_o  = view[IX_DATE];
  assign month_o = view[IX_MONTH];
  assign year_o  = view[IX_YEAR];
  assign roll_o  = roll_q;
endmodule

// File: rtl/rtcc_checker.sv
`timescale 1ns/1ps
module rtcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       freeze_i,
  input logic       mode_12h_i,
  input logic       wr_en_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] year_o,
  input logic [6:0] roll_o,
  input logic [7:0] live_sec,
  input logic [7:0] live_dow,
  input logic [7:0] live_date
);
  a_r1_sec_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o[0] |-> (live_sec == 8'h00));

  a_r11_min_needs_sec: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o[1] |-> roll_o[0]);

  a_r2_day_needs_hour: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_o[3] || roll_o[4]) |-> roll_o[2]);

  a_r7_year_needs_month: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o[6] |-> roll_o[5]);

  a_r3_hour_12h_form: assert property (@(posedge clk) disable iff (!rst_n)
    mode_12h_i |-> (hour_o[7] && !hour_o[6] && hour_o[4:0] != 5'h00 && hour_o[4:0] <= 5'h12));

  a_r6_dow_with_date: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en_i) && live_date != $past(live_date)) |-> (live_dow != $past(live_dow)));

  a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && $past(freeze_i)) |-> $stable({sec_o, min_o, date_o, year_o}));
endmodule

bind rtc_calendar_core rtcc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .freeze_i   (freeze_i),
  .mode_12h_i (mode_12h_i),
  .wr_en_i    (wr_en_i),
  .sec_o      (sec_o),
  .min_o      (min_o),
  .hour_o     (hour_o),
  .date_o     (date_o),
  .year_o     (year_o),
  .roll_o     (roll_o),
  .live_sec   (live_q[0]),
  .live_dow   (live_q[3]),
  .live_date  (live_q[4])
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, mode12 = 1'b0, wr = 1'b0, frz = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic [6:0] roll_o;

  int n_chk = 0, n_fail = 0;
  int m_psc, m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_roll;
  int s_sec, s_min, s_hr, s_dow, s_date, s_mon, s_yr;

  always #2.5 clk = ~clk;

  rtc_calendar_core #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_12h_i(mode12),
    .wr_en_i(wr), .wr_addr_i(addr), .wr_data_i(data), .freeze_i(frz),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .roll_o(roll_o)
  );

  function automatic int to_bcd(int b); return (b / 10) * 16 + (b % 10); endfunction
  function automatic int from_bcd(int v); return ((v >> 4) & 15) * 10 + (v & 15); endfunction
  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic int ext_hour(int h, bit m12);
    int hh;
    if (!m12) return to_bcd(h);
    hh = (h % 12 == 0) ? 12 : h % 12;
    return 128 + ((h >= 12) ? 32 : 0) + to_bcd(hh);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_psc = 0; m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0; m_roll = 0;
    s_sec = 0; s_min = 0; s_hr = 0; s_dow = 1; s_date = 1; s_mon = 1; s_yr = 0;
  endtask

  task automatic model_edge(bit tk, bit w, int a, int d, bit f);
    bit st, cs, cm, ch, cd, cmo;
    int dim, h;
    st = 0; cs = 0; cm = 0; ch = 0; cd = 0; cmo = 0;
    dim = days_in(m_mon, m_yr);
    m_roll = 0;
    if (w && a == 0) m_psc = 0;
    else if (tk) begin
      if (m_psc == TPS - 1) begin m_psc = 0; st = 1; end else m_psc++;
    end
    if (w && a == 0) m_sec = from_bcd(d);
    else if (st) begin if (m_sec == 59) begin m_sec = 0; cs = 1; end else m_sec++; end
    if (w && a == 1) m_min = from_bcd(d);
    else if (cs) begin if (m_min == 59) begin m_min = 0; cm = 1; end else m_min++; end
    if (w && a == 2) begin
      if (d[7]) begin h = from_bcd(d & 31); m_hr = (h % 12) + (d[5] ? 12 : 0); end
      else m_hr = from_bcd(d & 63);
    end else if (cm) begin if (m_hr == 23) begin m_hr = 0; ch = 1; end else m_hr++; end
    if (w && a == 3) m_dow = d;
    else if (ch) begin if (m_dow == 7) begin m_dow = 1; m_roll |= 8; end else m_dow++; end
    if (w && a == 4) m_date = from_bcd(d);
    else if (ch) begin if (m_date == dim) begin m_date = 1; cd = 1; end else m_date++; end
    if (w && a == 5) m_mon = from_bcd(d);
    else if (cd) begin if (m_mon == 12) begin m_mon = 1; cmo = 1; end else m_mon++; end
    if (w && a == 6) m_yr = from_bcd(d);
    else if (cmo) begin if (m_yr == 99) begin m_yr = 0; m_roll |= 64; end else m_yr++; end
    m_roll |= (cs ? 1 : 0) | (cm ? 2 : 0) | (ch ? 4 : 0) | (cd ? 16 : 0) | (cmo ? 32 : 0);
    if (!f) begin
      s_sec = m_sec; s_min = m_min; s_hr = m_hr; s_dow = m_dow;
      s_date = m_date; s_mon = m_mon; s_yr = m_yr;
    end
  endtask

  task automatic compare_all();
    check("R1 seconds", sec_o, to_bcd(frz ? s_sec : m_sec));
    check("R1 minutes", min_o, to_bcd(frz ? s_min : m_min));
    check("R3 hour",    hour_o, ext_hour(frz ? s_hr : m_hr, mode12));
    check("R6 dow",     dow_o, frz ? s_dow : m_dow);
    check("R4 date",    date_o, to_bcd(frz ? s_date : m_date));
    check("R7 month",   month_o, to_bcd(frz ? s_mon : m_mon));
    check("R7 year",    year_o, to_bcd(frz ? s_yr : m_yr));
    check("R11 roll",   roll_o, m_roll);
  endtask

  task automatic cyc(bit tk, bit w, int a, int d, bit f);
    @(negedge clk);
    tick = tk; wr = w; addr = 3'(a); data = 8'(d); frz = f;
    @(posedge clk);
    #1;
    model_edge(tk, w, a, d, f);
    compare_all();
  endtask

  task automatic set_time(int yr, int mo, int dt, int dw, int hr, int mi, int se);
    cyc(0, 1, 6, yr, 0); cyc(0, 1, 5, mo, 0); cyc(0, 1, 4, dt, 0); cyc(0, 1, 3, dw, 0);
    cyc(0, 1, 2, hr, 0); cyc(0, 1, 1, mi, 0); cyc(0, 1, 0, se, 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
  endtask

  function automatic int rand_val(int a);
    case (a)
      0, 1: return ($urandom % 2) ? to_bcd(55 + $urandom % 5) : to_bcd($urandom % 60);
      2: return ($urandom % 2) ? (128 + (($urandom % 2) ? 32 : 0) + to_bcd(1 + $urandom % 12))
                               : to_bcd(($urandom % 2) ? 23 : $urandom % 24);
      3: return 1 + $urandom % 7;
      4: return to_bcd(($urandom % 2) ? days_in(m_mon, m_yr) : 1 + $urandom % 28);
      5: return to_bcd(($urandom % 2) ? 12 : 1 + $urandom % 12);
      default: return to_bcd(($urandom % 2) ? 99 : $urandom % 100);
    endcase
  endfunction

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int keep [8];
    void'($urandom(32'd2718));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R12 reset values
    check("R12 sec", sec_o, 'h00); check("R12 hour", hour_o, 'h00);
    check("R12 dow", dow_o, 'h01); check("R12 date", date_o, 'h01);
    check("R12 month", month_o, 'h01); check("R12 year", year_o, 'h00);
    check("R12 roll", roll_o, 0);

    // R1 prescaler ratio
    ticks(TPS - 1); check("R1 before step", sec_o, 'h00);
    ticks(1);       check("R1 after step", sec_o, 'h01);

    // R5 leap February, R6 dow with date, R11 strobes
    set_time('h24, 'h02, 'h28, 3, 'h23, 'h59, 'h59);
    ticks(TPS);
    check("R5 leap date", date_o, 'h29); check("R5 leap month", month_o, 'h02);
    check("R6 dow step", dow_o, 'h04);   check("R2 hour wrap", hour_o, 'h00);
    check("R11 roll sec/min/hour", roll_o, 'h07);
    ticks(TPS * 86400 / 86400); // one more second only
    check("R11 roll clear", roll_o, 'h00);

    // R4 non-leap February and a 30-day month
    set_time('h23, 'h02, 'h28, 2, 'h23, 'h59, 'h59);
    ticks(TPS);
    check("R4 feb end date", date_o, 'h01); check("R4 feb end month", month_o, 'h03);
    set_time('h23, 'h04, 'h30, 2, 'h23, 'h59, 'h59);
    ticks(TPS);
    check("R4 april end date", date_o, 'h01); check("R4 april end month", month_o, 'h05);
    // R5 year 00 is leap
    set_time('h00, 'h02, 'h28, 5, 'h23, 'h59, 'h59);
    ticks(TPS);
    check("R5 year00 leap", date_o, 'h29);

    // R7 full wrap
    set_time('h99, 'h12, 'h31, 7, 'h23, 'h59, 'h59);
    ticks(TPS);
    check("R7 year wrap", year_o, 'h00); check("R7 month wrap", month_o, 'h01);
    check("R6 dow wrap", dow_o, 'h01);   check("R11 roll all", roll_o, 'h7F);

    // R3 12-hour form
    mode12 = 1'b1;
    set_time('h10, 'h06, 'h10, 1, 'h91, 'h59, 'h59);
    check("R3 11 am", hour_o, 'h91);
    ticks(TPS);
    check("R3 noon pm", hour_o, 'hB2);
    mode12 = 1'b0;
    #1 check("R3 24h view", hour_o, 'h12);
    mode12 = 1'b1;
    set_time('h10, 'h06, 'h10, 1, 'hB1, 'h59, 'h59);
    ticks(TPS);
    check("R3 midnight am", hour_o, 'h92); check("R3 day step", date_o, 'h11);
    mode12 = 1'b0;

    // R9 seconds write restarts the prescaler
    ticks(2);
    cyc(0, 1, 0, 'h30, 0);
    ticks(TPS - 1); check("R9 no early step", sec_o, 'h30);
    ticks(1);       check("R9 step after full second", sec_o, 'h31);

    // R8 collision: minutes write with the wrapping tick
    set_time('h10, 'h06, 'h10, 1, 'h08, 'h10, 'h59);
    ticks(TPS - 1);
    cyc(1, 1, 1, 'h45, 0);
    check("R8 written min", min_o, 'h45); check("R8 sec wrapped", sec_o, 'h00);
    check("R8 roll only sec", roll_o, 'h01);
    // R8/R9 seconds write with the final tick
    ticks(TPS - 1);
    cyc(1, 1, 0, 'h20, 0);
    check("R9 written sec", sec_o, 'h20); check("R9 min kept", min_o, 'h45);
    // R8 select 7 ignored
    keep = '{sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, 0};
    cyc(0, 1, 7, 'h55, 0);
    check("R8 sel7 sec", sec_o, keep[0]);   check("R8 sel7 min", min_o, keep[1]);
    check("R8 sel7 hour", hour_o, keep[2]); check("R8 sel7 dow", dow_o, keep[3]);
    check("R8 sel7 date", date_o, keep[4]); check("R8 sel7 month", month_o, keep[5]);
    check("R8 sel7 year", year_o, keep[6]);

    // R10 freeze
    set_time('h10, 'h06, 'h10, 1, 'h08, 'h00, 'h10);
    cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 3 * TPS; i++) cyc(1, 0, 0, 0, 1);
    check("R10 held", sec_o, 'h10);
    cyc(0, 0, 0, 0, 0);
    check("R10 caught up", sec_o, 'h13);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      bit tk, w, f;
      int a, d;
      tk = ($urandom % 10) < 7;
      w = ($urandom % 20) == 0;
      a = $urandom % 8;
      d = rand_val(a);
      if (w && (a == 5 || a == 6) && m_date > 28) w = 0;
      if (($urandom % 30) == 0) f = !frz; else f = frz;
      if (($urandom % 200) == 0) mode12 = !mode12;
      cyc(tk, w, a, d, f);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule